// File: doc/BRIEF.md
# Eight-Operation Byte ALU

This block is a purely combinational arithmetic logic unit for byte-wide operands. A 3-bit operation code picks one of eight functions of two operands and a carry input: four bitwise functions and four additive functions (subtract-style add with inverted second operand, full add, decrement-with-carry and increment-by-carry). It is used as an execution leaf inside a larger datapath. The owning pipeline supplies operands and an operation code. It reads the result, a sign flag, a carry flag and a signed-overflow flag in the same cycle.

The three additive functions that take both a second operand and the carry input are built in two steps. The first step adds the operand pair. The second step adds the zero-extended carry input to that sum. The reported carry is the OR of the two step carries, and the reported overflow is the OR of the two step overflows. This rule has a visible consequence: an intermediate overflow stays flagged even when the final value would fit. A single enable input zeroes every output when low.

Top module: `byte_alu_core`

## Requirements
- R1: The operation code selects the bitwise functions as follows: 3'b000 gives A OR B, 3'b001 gives NOT A, 3'b100 gives A XOR B, 3'b101 gives A AND B.
- R2: For the four bitwise codes (000, 001, 100, 101) with enable high, carry and overflow outputs are 0.
- R3: Code 3'b010 computes step 1 = A + NOT B, then step 2 = step 1 + zero-extended carry-in. The result is the step 2 sum, carry is the OR of the step carries, and overflow is the OR of the step overflows (A=0xAA, B=0x55, cin=0 gives 0x54, carry 1, overflow 1).
- R4: Code 3'b011 follows the rule of R3 with B in place of NOT B (A=0xAA, B=0x55, cin=1 gives 0x00, carry 1, overflow 0; A=0x80, B=0xFF, cin=1 gives 0x80, carry 1, overflow 1).
- R5: Code 3'b110 follows the rule of R3 with 0xFF in place of NOT B (A=0x80, cin=0 gives 0x7F, carry 1, overflow 1).
- R6: Code 3'b111 is one addition of A and the zero-extended carry-in, reporting that addition's carry and overflow (0xFF+1 gives 0x00 with carry 1 and overflow 0).
- R7: Each addition step flags overflow exactly when its two addends share a sign bit and its sum has the other sign bit (0x7F+1 under code 111 gives 0x80 with overflow 1).
- R8: The sign output always equals bit 7 of the result output.
- R9: With enable low, the result, sign, carry and overflow outputs are all 0, for every operation code, operand and carry-in.
- R10: The outputs follow input changes within the same cycle, with no clock and no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Output enable; low forces all outputs to zero |
| op_i | input | 3 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry input folded into the additive functions |
| m_o | output | 8 | Selected result |
| sign_o | output | 1 | Bit 7 of the result |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
Two events can fall in the same evaluation: an overflow in the operand step and a second overflow in the carry step. The bench provokes this with code 011, A=0x80, B=0xFF and cin=1. Step one wraps to 0x7F, and step two wraps that value back to 0x80. The OR rule must then report overflow even though the true signed sum fits. The bench judges each case against a behavioural model that derives every step flag from the integer range of the signed sum. It also derives each step carry from the unsigned range. Enable low is applied to the same flag-raising operands, so the bench confirms that the gating wins over both flags at once.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_OR     = 3'b000,
        OP_INV_A  = 3'b001,
        OP_ADD_NB = 3'b010,
        OP_ADD_B  = 3'b011,
        OP_XOR    = 3'b100,
        OP_AND    = 3'b101,
        OP_DEC    = 3'b110,
        OP_INC    = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } alu_flags_t;

    function automatic logic is_bitwise(alu_op_e op);
        return (op == OP_OR) || (op == OP_INV_A) || (op == OP_XOR) || (op == OP_AND);
    endfunction

    function automatic alu_flags_t merge_flags(alu_flags_t x, alu_flags_t y);
        alu_flags_t r;
        r.carry = x.carry | y.carry;
        r.ovf   = x.ovf | y.ovf;
        return r;
    endfunction

endpackage

// File: rtl/ripple_stage.sv
module ripple_stage #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         ovf_o
);
    logic [W:0] chain;

    assign chain[0] = ci_i;

    for (genvar k = 0; k < W; k++) begin : g_bit
        logic p;
        assign p          = x_i[k] ^ y_i[k];
        assign sum_o[k]   = p ^ chain[k];
        assign chain[k+1] = (x_i[k] & y_i[k]) | (p & chain[k]);
    end

    assign co_o  = chain[W];
    assign ovf_o = chain[W] ^ chain[W-1];

    always_comb begin
        if (!$isunknown({x_i, y_i, ci_i})) begin
            // R7: sign-based overflow view agrees with the carry-chain view
            a_r7_step_overflow: assert (ovf_o == ((x_i[W-1] == y_i[W-1]) && (sum_o[W-1] != x_i[W-1])));
            a_r6_step_sum: assert ({co_o, sum_o} == ({1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, ci_i}));
        end
    end
endmodule

// File: rtl/two_step_adder.sv
module two_step_adder
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output alu_flags_t   flags_o
);
    localparam int unsigned PAD_W = W - 1;

    logic [W-1:0] part_sum;
    logic [W-1:0] cin_ext;
    alu_flags_t   fl_first;
    alu_flags_t   fl_second;

    assign cin_ext = {{PAD_W{1'b0}}, cin_i};

    ripple_stage #(.W(W)) u_first (
        .x_i   (a_i),
        .y_i   (b_i),
        .ci_i  (1'b0),
        .sum_o (part_sum),
        .co_o  (fl_first.carry),
        .ovf_o (fl_first.ovf)
    );

    ripple_stage #(.W(W)) u_second (
        .x_i   (part_sum),
        .y_i   (cin_ext),
        .ci_i  (1'b0),
        .sum_o (sum_o),
        .co_o  (fl_second.carry),
        .ovf_o (fl_second.ovf)
    );

    assign flags_o = merge_flags(fl_first, fl_second);

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            // R3: a nine-bit total never needs both steps to carry
            a_r3_single_carry: assert (!(fl_first.carry && fl_second.carry));
        end
    end
endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_OR:    y_o = a_i | b_i;
            OP_INV_A: y_o = ~a_i;
            OP_XOR:   y_o = a_i ^ b_i;
            OP_AND:   y_o = a_i & b_i;
            default:  y_o = '0;
        endcase
    end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         en_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] m_o,
    output logic         sign_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int unsigned MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] addend;
    logic [W-1:0] add_sum;
    alu_flags_t   add_flags;
    logic [W-1:0] bit_y;
    logic [W-1:0] sel_data;
    alu_flags_t   sel_flags;

    assign op = alu_op_e'(op_i);

    always_comb begin
        unique case (op)
            OP_ADD_NB: addend = ~b_i;
            OP_ADD_B:  addend = b_i;
            OP_DEC:    addend = '1;
            default:   addend = '0;
        endcase
    end

    two_step_adder #(.W(W)) u_adder (
        .a_i     (a_i),
        .b_i     (addend),
        .cin_i   (cin_i),
        .sum_o   (add_sum),
        .flags_o (add_flags)
    );

    bitwise_unit #(.W(W)) u_bitwise (
        .op_i (op),
        .a_i  (a_i),
        .b_i  (b_i),
        .y_o  (bit_y)
    );

    always_comb begin
        if (is_bitwise(op)) begin
            sel_data  = bit_y;
            sel_flags = '0;
        end else begin
            sel_data  = add_sum;
            sel_flags = add_flags;
        end
    end

    assign m_o     = en_i ? sel_data : '0;
    assign sign_o  = en_i & sel_data[MSB];
    assign carry_o = en_i & sel_flags.carry;
    assign ovf_o   = en_i & sel_flags.ovf;

    always_comb begin
        if (!$isunknown({en_i, op_i, a_i, b_i, cin_i})) begin
            a_r8_sign_msb: assert (sign_o == m_o[MSB]);
            a_r9_disabled_quiet: assert (en_i || ({m_o, sign_o, carry_o, ovf_o} == '0));
            a_r2_bitwise_flags: assert (!(en_i && is_bitwise(op)) || (!carry_o && !ovf_o));
            a_r1_bitwise_pass: assert (!(en_i && is_bitwise(op)) || (m_o == bit_y));
        end
    end
endmodule

// File: tb/byte_alu_core_tb.sv
module byte_alu_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en;
    logic [2:0] op;
    logic [7:0] a, b;
    logic       cin;
    logic [7:0] m;
    logic       sign, carry, ovf;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_alu_core dut_i (
        .en_i(en), .op_i(op), .a_i(a), .b_i(b), .cin_i(cin),
        .m_o(m), .sign_o(sign), .carry_o(carry), .ovf_o(ovf)
    );

    // one addition step: {carry, ovf, sum} from integer ranges
    function automatic logic [9:0] step_add(int x, int y);
        int u  = x + y;
        int sx = (x > 127) ? x - 256 : x;
        int sy = (y > 127) ? y - 256 : y;
        int s  = sx + sy;
        logic [9:0] r;
        r[9]   = (u > 255);
        r[8]   = (s > 127) || (s < -128);
        r[7:0] = u[7:0];
        return r;
    endfunction

    // model: {m, carry, ovf}
    function automatic logic [9:0] model(logic e, logic [2:0] o, logic [7:0] x, logic [7:0] y, logic c);
        logic [9:0] s1, s2;
        logic [7:0] second;
        logic [9:0] r;
        if (!e) return 10'd0;
        case (o)
            3'd0: return {x | y, 2'b00};
            3'd1: return {~x, 2'b00};
            3'd4: return {x ^ y, 2'b00};
            3'd5: return {x & y, 2'b00};
            3'd7: begin
                s1 = step_add(int'(x), int'(c));
                return {s1[7:0], s1[9], s1[8]};
            end
            default: begin
                second = (o == 3'd2) ? ~y : (o == 3'd3) ? y : 8'hFF;
                s1 = step_add(int'(x), int'(second));
                s2 = step_add(int'(s1[7:0]), int'(c));
                r  = {s2[7:0], s1[9] | s2[9], s1[8] | s2[8]};
                return r;
            end
        endcase
    endfunction

    function automatic string op_tag(logic e, logic [2:0] o);
        if (!e) return "R9";
        case (o)
            3'd2: return "R3";
            3'd3: return "R4";
            3'd6: return "R5";
            3'd7: return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic judge(string tag);
        logic [9:0] e = model(en, op, a, b, cin);
        string ftag = (en && (op inside {3'd0, 3'd1, 3'd4, 3'd5})) ? "R2" : tag;
        cmp(tag, "result", int'(m), int'(e[9:2]));
        cmp(ftag, "carry", int'(carry), int'(e[1]));
        cmp(ftag, "overflow", int'(ovf), int'(e[0]));
        cmp("R8", "sign", int'(sign), int'(e[9]));
    endtask

    task automatic run(string tag, logic e, logic [2:0] o, logic [7:0] x, logic [7:0] y, logic c);
        @(posedge clk);
        #1;
        en = e; op = o; a = x; b = y; cin = c;
        @(negedge clk);
        judge(tag);
    endtask

    task automatic expect_vals(string tag, logic [7:0] em, logic ec, logic ev);
        cmp(tag, "result", int'(m), int'(em));
        cmp(tag, "carry", int'(carry), int'(ec));
        cmp(tag, "overflow", int'(ovf), int'(ev));
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG_CYCLES);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] corner [4];
        corner[0] = 8'h00; corner[1] = 8'hFF; corner[2] = 8'h7F; corner[3] = 8'h80;
        en = 1'b0; op = 3'd3; a = 8'hFF; b = 8'hFF; cin = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: state during and after reset with enable low
        expect_vals("R9", 8'h00, 1'b0, 1'b0);
        cmp("R9", "sign", int'(sign), 0);

        // directed values
        run("R3", 1, 3'd2, 8'hAA, 8'h55, 0); expect_vals("R3", 8'h54, 1, 1);
        run("R3", 1, 3'd2, 8'hAA, 8'h55, 1); expect_vals("R3", 8'h55, 1, 1);
        run("R4", 1, 3'd3, 8'hAA, 8'h55, 1); expect_vals("R4", 8'h00, 1, 0);
        run("R4", 1, 3'd3, 8'h80, 8'hFF, 1); expect_vals("R4", 8'h80, 1, 1);
        run("R5", 1, 3'd6, 8'hAA, 8'h00, 0); expect_vals("R5", 8'hA9, 1, 0);
        run("R5", 1, 3'd6, 8'h80, 8'h00, 0); expect_vals("R5", 8'h7F, 1, 1);
        run("R7", 1, 3'd7, 8'h7F, 8'h00, 1); expect_vals("R7", 8'h80, 0, 1);
        run("R6", 1, 3'd7, 8'hFF, 8'h00, 1); expect_vals("R6", 8'h00, 1, 0);
        run("R1", 1, 3'd0, 8'hAA, 8'h55, 0); expect_vals("R1", 8'hFF, 0, 0);
        run("R1", 1, 3'd1, 8'hAA, 8'h00, 1); expect_vals("R1", 8'h55, 0, 0);
        run("R1", 1, 3'd4, 8'hF0, 8'hF0, 1); expect_vals("R1", 8'h00, 0, 0);
        run("R1", 1, 3'd5, 8'hAA, 8'hAA, 1); expect_vals("R1", 8'hAA, 0, 0);
        // R9: both stage overflows pending, enable low
        run("R9", 0, 3'd3, 8'h80, 8'hFF, 1); expect_vals("R9", 8'h00, 0, 0);

        // R10: change inputs mid-cycle, outputs follow without an edge
        #1; a = 8'h01; b = 8'h02; en = 1'b1; op = 3'd3; cin = 1'b0;
        #1; expect_vals("R10", 8'h03, 0, 0);
        #1; cin = 1'b1;
        #1; expect_vals("R10", 8'h04, 0, 0);

        // corner sweep over every code, enable both ways
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    for (int c = 0; c < 2; c++)
                        for (int e = 0; e < 2; e++)
                            run(op_tag(e[0], o[2:0]), e[0], o[2:0], corner[i], corner[j], c[0]);

        // random operands
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom();
            logic e = (r[31:28] != 4'd0);
            run(op_tag(e, r[2:0]), e, r[2:0], r[10:3], r[18:11], r[19]);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule